// File: doc/BRIEF.md
# Display Link Packet Builder

This block turns packet requests into the byte stream of a serial display link. A request carries an identifier byte and a 16-bit field. The identifier's type bits decide the form of the packet. In a short packet the field holds two data bytes. In a long packet it holds the payload length, and the payload bytes then arrive on their own valid/ready input. The builder adds the header error-correction byte. For long packets it also appends a 16-bit payload checksum. Every byte leaves on one valid/ready output, and a last flag marks the final byte of each packet.

The builder takes one request at a time. While a packet is being sent, the request port is closed. Payload bytes pass straight through to the output in the payload phase, so a stall on the output side reaches the payload source in the same cycle. No byte is lost or sent twice.

Top module: `lnk_pkt_builder`

## Requirements
- R1: A short packet is exactly four output bytes: the identifier, then the field's low byte, then the field's high byte, then the ECC byte. The last flag is set only on the ECC byte. The first byte appears on the cycle after the request is accepted.
- R2: A long packet sends these bytes in order: the identifier, the word count low byte, the word count high byte, the ECC byte, exactly word-count payload bytes in arrival order, the checksum low byte and the checksum high byte. The last flag is set only on the checksum high byte.
- R3: The form is chosen from the low six bits of the identifier. The packet is long when bits [3:0] equal 0x9, 0xC, 0xD or 0xE, and short otherwise. Bits [7:6] (channel number) play no part in the choice, but they are sent unchanged and covered by the ECC.
- R4: The ECC is a 6-bit Hamming parity over 24 header bits: identifier in bits 0-7, field low byte in bits 8-15, field high byte in bits 16-23. ECC bits 7:6 are zero. Header 0x37,0x03,0x00 gives 0x01, and header 0x39,0x03,0x00 gives 0x09.
- R5: The checksum is a reflected CRC-16 (polynomial x^16+x^12+x^5+1, 0x8408 reflected), seeded with 0xFFFF, updated LSB first over payload bytes only, and sent low byte first. Payload 0xB6,0xB2,0xB2 ends with 0xEF then 0xFA.
- R6: A long packet with word count 0 sends its header followed directly by 0xFF, 0xFF.
- R7: While the output is valid and not ready, the output stays valid and its data and last flag stay stable. Back-pressure never drops or repeats a byte.
- R8: The payload input is ready only during the payload phase of a long packet, and only while the output is ready. Bytes offered during a short packet or a header are ignored. Exactly word-count payload bytes are consumed per packet.
- R9: The request port is ready only when no packet is in progress. After the last byte is accepted, it is ready again on the next cycle.
- R10: After reset the request port is ready, the output is not valid, and the payload input is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Packet request offered |
| req_ready | output | 1 | Builder idle and able to take a request |
| req_di | input | 8 | Identifier byte: channel in [7:6], type in [5:0] |
| req_field | input | 16 | Two data bytes (short) or word count (long), sent low byte first |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The assertions check, on every cycle, the rules of both handshakes. A stalled output holds its byte and flag. The payload input is never ready unless the output is ready. The request port is closed while bytes flow and reopens right after a last byte. The first byte after an accepted request is its identifier, the ECC position carries zero top bits, and no packet ends before its fourth byte. The values of the ECC and checksum bytes, the choice between short and long forms, exact byte counts, and stray payload bytes being ignored can only be shown by the bench's scenarios. Those scenarios compare whole packets against stream images built from the requirements, under random stalls on both sides.

// File: rtl/lnk_pkt_pkg.sv
package lnk_pkt_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned HDR_W  = 3 * BYTE_W;
  localparam int unsigned ECC_W  = 6;
  localparam int unsigned CRC_W  = 16;

  // Header bits covered by each parity bit (bit 0 = identifier LSB).
  localparam logic [HDR_W-1:0] ECC_MASK [ECC_W] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D,
    24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_F0, ST_F1, ST_ECC, ST_PAY, ST_CK0, ST_CK1
  } pkt_state_t;

  // Long form when the type's low nibble is 9, C, D or E.
  function automatic logic long_form(input logic [5:0] dt);
    logic [3:0] nib;
    nib = dt[3:0];
    return (nib == 4'h9) || (nib == 4'hC) || (nib == 4'hD) || (nib == 4'hE);
  endfunction

endpackage

// File: rtl/lnk_pkt_hdr.sv
module lnk_pkt_hdr
  import lnk_pkt_pkg::*;
(
  input  logic [BYTE_W-1:0] di,
  input  logic [CNT_W-1:0]  fld,
  output logic              is_long,
  output logic [BYTE_W-1:0] ecc
);

  logic [HDR_W-1:0] hdr;
  assign hdr = {fld, di};

  generate
    for (genvar g = 0; g < ECC_W; g++) begin : g_par
      assign ecc[g] = ^(hdr & ECC_MASK[g]);
    end
  endgenerate

  assign ecc[BYTE_W-1:ECC_W] = '0;
  assign is_long = long_form(di[5:0]);

endmodule

// File: rtl/lnk_pkt_crc.sv
module lnk_pkt_crc
  import lnk_pkt_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] step;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  always_comb begin
    logic fb;
    step = crc_q;
    for (int b = 0; b < BYTE_W; b++) begin
      fb   = step[0] ^ din[b];
      step = step >> 1;
      if (fb) step = step ^ POLY;
    end
  end

  assign crc_en = init | upd;
  assign crc_d  = init ? SEED : step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/lnk_pkt_builder.sv
module lnk_pkt_builder
  import lnk_pkt_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] req_di,
  input  logic [CNT_W-1:0]  req_field,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);

  // Reset synchronizer: asserted at once, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  pkt_state_t        state_q, state_d;
  logic [BYTE_W-1:0] di_q;
  logic [CNT_W-1:0]  fld_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              accept;
  logic              fire;
  logic              pay_fire;
  logic              is_long;
  logic [BYTE_W-1:0] ecc;
  logic [CRC_W-1:0]  crc;

  lnk_pkt_hdr u_hdr (
    .di      (di_q),
    .fld     (fld_q),
    .is_long (is_long),
    .ecc     (ecc)
  );

  lnk_pkt_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .init  (accept),
    .upd   (pay_fire),
    .din   (pl_data),
    .crc   (crc)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fire      = out_valid && out_ready;
  assign pay_fire  = fire && (state_q == ST_PAY);

  // Output side
  always_comb begin
    out_valid = 1'b1;
    pl_ready  = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    unique case (state_q)
      ST_IDLE: out_valid = 1'b0;
      ST_ID:   out_data  = di_q;
      ST_F0:   out_data  = fld_q[BYTE_W-1:0];
      ST_F1:   out_data  = fld_q[CNT_W-1:BYTE_W];
      ST_ECC: begin
        out_data = ecc;
        out_last = !is_long;
      end
      ST_PAY: begin
        out_valid = pl_valid;
        pl_ready  = out_ready;
        out_data  = pl_data;
      end
      ST_CK0:  out_data  = crc[BYTE_W-1:0];
      ST_CK1: begin
        out_data = crc[CRC_W-1:BYTE_W];
        out_last = 1'b1;
      end
      default: out_valid = 1'b0;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ID;
      ST_ID:   if (fire)   state_d = ST_F0;
      ST_F0:   if (fire)   state_d = ST_F1;
      ST_F1:   if (fire)   state_d = ST_ECC;
      ST_ECC:
        if (fire) begin
          if (!is_long)         state_d = ST_IDLE;
          else if (cnt_q == '0) state_d = ST_CK0;
          else                  state_d = ST_PAY;
        end
      ST_PAY:  if (fire && cnt_q == CNT_W'(1)) state_d = ST_CK0;
      ST_CK0:  if (fire) state_d = ST_CK1;
      ST_CK1:  if (fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = accept | pay_fire;
  assign cnt_d  = accept ? req_field : (cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      di_q  <= '0;
      fld_q <= '0;
    end else if (accept) begin
      di_q  <= req_di;
      fld_q <= req_field;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lnk_pkt_builder_chk.sv
module lnk_pkt_builder_chk
  import lnk_pkt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BYTE_W-1:0] req_di,
  input logic              pl_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_last
);

  // Position of the current output byte inside its packet (saturating).
  logic [2:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 3'd0;
    else if (out_valid && out_ready) begin
      if (out_last)          pos_q <= 3'd0;
      else if (pos_q < 3'd5) pos_q <= pos_q + 3'd1;
    end
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_pl_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> out_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid && !pl_ready);

  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> req_ready);

  p_first_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid && out_data == $past(req_di));

  p_ecc_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos_q == 3'd3 |-> out_data[7:6] == 2'b00);

  p_min_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> pos_q >= 3'd3);

endmodule

bind lnk_pkt_builder lnk_pkt_builder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_di    (req_di),
  .pl_ready  (pl_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/lnk_pkt_builder_tb.sv
module lnk_pkt_builder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_di;
  logic [15:0] req_field;
  logic        pl_valid;
  logic        pl_ready;
  logic [7:0]  pl_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_err = 0;
  int pl_taken = 0;
  bit stall_mode = 1'b0;

  logic [7:0] got_d[$];
  logic       got_l[$];
  logic [7:0] pay[$];

  always #4 clk = ~clk;

  lnk_pkt_builder u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_di(req_di), .req_field(req_field),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Bench model: syndrome column of each header bit.
  function automatic logic [5:0] col_code(input int i);
    case (i)
      0: return 6'h07;  1: return 6'h0B;  2: return 6'h0D;  3: return 6'h0E;
      4: return 6'h13;  5: return 6'h15;  6: return 6'h16;  7: return 6'h19;
      8: return 6'h1A;  9: return 6'h1C; 10: return 6'h23; 11: return 6'h25;
     12: return 6'h26; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h2C;
     16: return 6'h31; 17: return 6'h32; 18: return 6'h34; 19: return 6'h38;
     20: return 6'h1F; 21: return 6'h2F; 22: return 6'h37; default: return 6'h3B;
    endcase
  endfunction

  function automatic logic [7:0] b_ecc(input logic [7:0] di, input logic [15:0] f);
    logic [23:0] h;
    logic [5:0]  e;
    h = {f, di};
    e = '0;
    for (int i = 0; i < 24; i++) if (h[i]) e = e ^ col_code(i);
    return {2'b00, e};
  endfunction

  function automatic logic [15:0] b_crc();
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (pay[k]) begin
      c = c ^ {8'h00, pay[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit b_long(input logic [7:0] di);
    return (di[3:0] == 4'h9) || (di[3:0] >= 4'hC && di[3:0] <= 4'hE);
  endfunction

  // Output collector and payload monitor, sampled 1 ns before the edge.
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
      #3;
      if (rst_n && out_valid && out_ready) begin
        got_d.push_back(out_data);
        got_l.push_back(out_last);
      end
      if (rst_n && pl_valid && pl_ready) pl_taken++;
      if (rst_n && out_valid && req_ready) busy_err++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_pkt(input logic [7:0] di, input logic [15:0] fld, input string rq);
    logic [7:0] exp_d[$];
    logic [15:0] c;
    bit lng;
    bit ok;
    lng = b_long(di);
    exp_d.push_back(di);
    exp_d.push_back(fld[7:0]);
    exp_d.push_back(fld[15:8]);
    exp_d.push_back(b_ecc(di, fld));
    if (lng) begin
      foreach (pay[k]) exp_d.push_back(pay[k]);
      c = b_crc();
      exp_d.push_back(c[7:0]);
      exp_d.push_back(c[15:8]);
    end
    got_d.delete();
    got_l.delete();
    pl_taken = 0;
    @(negedge clk);
    if (!lng) begin
      pl_valid = 1'b1;           // stray byte that must be ignored (R8)
      pl_data  = 8'hA5;
    end
    fork
      begin
        req_valid = 1'b1;
        req_di    = di;
        req_field = fld;
        do begin
          #3;
          ok = req_ready;
          @(negedge clk);
        end while (!ok);
        req_valid = 1'b0;
        req_di    = 8'($urandom);
        req_field = 16'($urandom);
      end
      begin
        if (lng) begin
          for (int i = 0; i < pay.size(); i++) begin
            int gap;
            bit pk;
            gap = $urandom % 3;
            if (gap != 0) begin
              pl_valid = 1'b0;
              repeat (gap) @(negedge clk);
            end
            pl_valid = 1'b1;
            pl_data  = pay[i];
            do begin
              #3;
              pk = pl_ready;
              @(negedge clk);
            end while (!pk);
          end
          pl_valid = 1'b0;
        end
      end
    join
    while (got_d.size() < exp_d.size()) @(posedge clk);
    repeat (4) @(negedge clk);
    pl_valid = 1'b0;
    chk(got_d.size() == exp_d.size(), rq, "byte count", got_d.size(), exp_d.size());
    begin
      int bad;
      int bad_act;
      int bad_exp;
      bad = -1; bad_act = 0; bad_exp = 0;
      for (int i = 0; i < exp_d.size() && i < got_d.size(); i++)
        if (bad < 0 && got_d[i] !== exp_d[i]) begin
          bad = i; bad_act = got_d[i]; bad_exp = exp_d[i];
        end
      chk(bad < 0, rq, $sformatf("byte %0d", bad), bad_act, bad_exp);
      bad = -1;
      for (int i = 0; i < got_l.size(); i++)
        if (bad < 0 && got_l[i] !== (i == exp_d.size() - 1)) bad = i;
      chk(bad < 0, lng ? "R2" : "R1", "last flag position", bad, exp_d.size() - 1);
    end
    chk(pl_taken == (lng ? pay.size() : 0), "R8", "payload bytes consumed", pl_taken, lng ? pay.size() : 0);
    chk(req_ready === 1'b1, "R9", "request port reopened", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h0005EED1));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_di    = '0;
    req_field = '0;
    pl_valid  = 1'b0;
    pl_data   = '0;
    repeat (3) @(negedge clk);
    #3;
    chk(req_ready === 1'b1, "R10", "req_ready in reset", req_ready, 1);
    chk(out_valid === 1'b0, "R10", "out_valid in reset", out_valid, 0);
    chk(pl_ready === 1'b0,  "R10", "pl_ready in reset", pl_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk(req_ready === 1'b1 && out_valid === 1'b0, "R10", "idle after reset", out_valid, 0);

    // R4: short packet with known ECC
    pay.delete();
    run_pkt(8'h37, 16'h0003, "R1");
    chk(got_d.size() > 3 && got_d[3] == 8'h01, "R4", "ECC of 37 03 00", got_d.size() > 3 ? got_d[3] : 0, 8'h01);

    // R5: long packet with known ECC and checksum
    pay.delete();
    pay.push_back(8'hB6); pay.push_back(8'hB2); pay.push_back(8'hB2);
    run_pkt(8'h39, 16'h0003, "R2");
    chk(got_d.size() > 3 && got_d[3] == 8'h09, "R4", "ECC of 39 03 00", got_d.size() > 3 ? got_d[3] : 0, 8'h09);
    chk(got_d.size() == 9 && got_d[7] == 8'hEF && got_d[8] == 8'hFA, "R5", "checksum bytes",
        got_d.size() == 9 ? {got_d[8], got_d[7]} : 0, 16'hFAEF);

    // R6: empty long packet
    pay.delete();
    run_pkt(8'h29, 16'h0000, "R6");
    chk(got_d.size() == 6 && got_d[4] == 8'hFF && got_d[5] == 8'hFF, "R6", "empty checksum",
        got_d.size() == 6 ? {got_d[5], got_d[4]} : 0, 16'hFFFF);

    // R3: channel bits do not change the form
    pay.delete();
    for (int i = 0; i < 4; i++) pay.push_back(8'(8'h10 + i));
    run_pkt(8'h4E, 16'h0004, "R3");
    pay.delete();
    for (int i = 0; i < 6; i++) pay.push_back(8'($urandom));
    run_pkt(8'hFE, 16'h0006, "R3");
    pay.delete();
    run_pkt(8'hC5, 16'hBEEF, "R3");
    chk(got_d.size() == 4, "R3", "channel bits on short type", got_d.size(), 4);

    // R7: random traffic under output stalls
    stall_mode = 1'b1;
    for (int n = 0; n < 30; n++) begin
      logic [7:0] dt;
      logic [15:0] f;
      case ($urandom % 16)
        0: dt = 8'h05;  1: dt = 8'h15;  2: dt = 8'h06;  3: dt = 8'h16;
        4: dt = 8'h37;  5: dt = 8'h03;  6: dt = 8'h13;  7: dt = 8'h23;
        8: dt = 8'h04;  9: dt = 8'h14; 10: dt = 8'h24; 11: dt = 8'h39;
       12: dt = 8'h29; 13: dt = 8'h0E; 14: dt = 8'h3E; default: dt = 8'h1E;
      endcase
      dt[7:6] = 2'($urandom);
      pay.delete();
      if (b_long(dt)) begin
        f = 16'($urandom % 24);
        for (int i = 0; i < int'(f); i++) pay.push_back(8'($urandom));
      end else begin
        f = 16'($urandom);
      end
      run_pkt(dt, f, "R7");
    end
    stall_mode = 1'b0;

    chk(busy_err == 0, "R9", "output valid while request port open", busy_err, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule